// File: doc/BRIEF.md
# FIFO-Paced Transfer Sequencer

This block runs one data transfer between a byte-wide bus-side window and a card-side word handshake, through a 512-byte staging FIFO. Software writes a single control word that carries a byte count, a direction, a bus width, a few stored attribute fields and a start bit. While start is set, the sequencer splits the count into FIFO-sized chunks. It raises a one-cycle buffer-available pulse whenever the next chunk can be serviced from the bus side. It raises a one-cycle transfer-done pulse when every byte has moved, and then clears start by itself.

In the write direction, the bus side pushes bytes into the FIFO and the card side drains them. In the read direction, the card side fills the FIFO and the bus side pops bytes. The bus side moves bytes only inside a chunk that has already been announced. The card side moves one or two bytes per handshake, according to the width field. A transfer-error input, or a new write of the control word, stops the transfer at once and empties the FIFO.

Top module: `fifo_xfer_seq`

## Requirements
- R1: After reset, the control readback is zero and buf_avail, done_evt and card_req are all low.
- R2: The control word layout is fixed. Bits 17:0 hold the count. Bit 24 is address-increment disable. Bit 25 is width (0 = 8-bit, 1 = 16-bit). Bit 26 is memory type. Bit 27 is memory/IO select. Bit 28 is DMA mode. Bit 30 is direction (0 = read, 1 = write). Bit 31 is start. Bits 29 and 23:18 read back as zero, and all other fields read back as written.
- R3: Every control write empties the FIFO and reloads the count. A write with start at 0 ends any transfer in progress, and afterwards no handshake request or event appears.
- R4: In the read direction, with no chunk open, buf_avail pulses for one cycle once the FIFO holds min(512, bytes the bus side still has to take). That pulse opens a chunk of that size.
- R5: In the write direction, with no chunk open, buf_avail pulses for one cycle once the FIFO has min(512, bytes the bus side still has to give) bytes free. That pulse opens a chunk of that size.
- R6: A bus strobe moves one byte only while a chunk is open and only in the strobe's own direction (bus_wr_en for write, bus_rd_en for read). Every other strobe is ignored.
- R7: card_req is high while card-side bytes remain and the FIFO can supply (write) or accept (read) the step. A handshake is card_req and card_ack in the same cycle. In 16-bit mode a handshake moves two bytes, with the earlier byte on bits 7:0. In 8-bit mode, and for a final odd byte, it moves one byte on bits 7:0, and card_wdata bits 15:8 are zero.
- R8: done_evt pulses for one cycle when both sides have moved the whole count, and start reads 0 from the next cycle on. done_evt and buf_avail are never high together.
- R9: A start with count 0 raises done_evt in the first cycle after the write. No request and no buf_avail appear.
- R10: pio_err during a transfer clears start, empties the FIFO and suppresses done_evt.
- R11: Bytes leave the FIFO in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word to write |
| ctl_rdata | output | 32 | Control word readback, with live start bit |
| pio_err | input | 1 | Transfer error, aborts the transfer |
| bus_wr_en | input | 1 | Bus-side byte push (write direction) |
| bus_wdata | input | 8 | Byte pushed from the bus side |
| bus_rd_en | input | 1 | Bus-side byte pop (read direction) |
| bus_rdata | output | 8 | Byte at the FIFO head for the bus side |
| card_req | output | 1 | Card-side handshake request |
| card_ack | input | 1 | Card-side handshake acknowledge |
| card_wdata | output | 16 | Data to the card (write direction) |
| card_rdata | input | 16 | Data from the card (read direction) |
| buf_avail | output | 1 | One-cycle pulse: next chunk can be serviced |
| done_evt | output | 1 | One-cycle pulse: whole count moved |

## Verification
A wrong FIFO level or pointer shows up as a wrong card_req or a wrong data byte. It is seen on the first handshake or bus pop that touches the bad entry, so at most one chunk later. A wrong remaining count or chunk size moves a buf_avail pulse, or done_evt, to the wrong cycle. The bench catches this on that same clock, because a per-clock model predicts every event cycle. A start bit that fails to clear shows on the readback one cycle after done or abort.

// File: rtl/fifo_xfer_seq.sv
module fifo_xfer_seq #(
  parameter int FIFO_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_rdata,
  input  logic        pio_err,
  input  logic        bus_wr_en,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_rd_en,
  output logic [7:0]  bus_rdata,
  output logic        card_req,
  input  logic        card_ack,
  output logic [15:0] card_wdata,
  input  logic [15:0] card_rdata,
  output logic        buf_avail,
  output logic        done_evt
);
  localparam int CNT_W = 18;
  localparam int PTR_W = $clog2(FIFO_BYTES);
  localparam int LVL_W = PTR_W + 1;
  localparam logic [30:0] CFG_MASK = 31'h5F03_FFFF;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_BYTES);

  logic [30:0]      cfg;
  logic             active;
  logic [CNT_W-1:0] card_left, bus_left;
  logic [LVL_W-1:0] ann_left, level;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [7:0]       mem [FIFO_BYTES];

  wire wdir = cfg[30];
  wire wide = cfg[25];
  wire [PTR_W-1:0] rd_p1 = rd_ptr + 1'b1;
  wire [PTR_W-1:0] wr_p1 = wr_ptr + 1'b1;
  wire [LVL_W-1:0] free_n = FULL - level;
  wire [LVL_W-1:0] step_n = (wide && card_left >= CNT_W'(2)) ? LVL_W'(2) : LVL_W'(1);
  wire [LVL_W-1:0] chunk = (bus_left < CNT_W'(FIFO_BYTES)) ? bus_left[LVL_W-1:0] : FULL;

  assign card_req  = active && card_left != '0 && (wdir ? level >= step_n : free_n >= step_n);
  assign buf_avail = active && ann_left == '0 && bus_left != '0 &&
                     (wdir ? free_n >= chunk : level >= chunk);
  assign done_evt  = active && card_left == '0 && bus_left == '0;

  wire bus_ok    = active && ann_left != '0 && (wdir ? level != FULL : level != '0);
  wire bus_fire  = bus_ok && (wdir ? bus_wr_en : bus_rd_en);
  wire card_fire = card_req && card_ack;

  wire [LVL_W-1:0] card_n = card_fire ? step_n : '0;
  wire [LVL_W-1:0] bus_n  = {{(LVL_W-1){1'b0}}, bus_fire};
  wire [LVL_W-1:0] push_n = wdir ? bus_n : card_n;
  wire [LVL_W-1:0] pop_n  = wdir ? card_n : bus_n;

  assign ctl_rdata  = {active, cfg};
  assign bus_rdata  = mem[rd_ptr];
  assign card_wdata = (step_n == LVL_W'(2)) ? {mem[rd_p1], mem[rd_ptr]} : {8'h00, mem[rd_ptr]};

  always_ff @(posedge clk) begin
    if (wdir && bus_fire) mem[wr_ptr] <= bus_wdata;
    if (!wdir && card_fire) begin
      mem[wr_ptr] <= card_rdata[7:0];
      if (step_n == LVL_W'(2)) mem[wr_p1] <= card_rdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      active    <= 1'b0;
      card_left <= '0;
      bus_left  <= '0;
      ann_left  <= '0;
      level     <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
    end else if (ctl_we) begin
      cfg       <= ctl_wdata[30:0] & CFG_MASK;
      active    <= ctl_wdata[31];
      card_left <= ctl_wdata[CNT_W-1:0];
      bus_left  <= ctl_wdata[CNT_W-1:0];
      ann_left  <= '0;
      level     <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
    end else if (pio_err || done_evt) begin
      active    <= 1'b0;
      card_left <= '0;
      bus_left  <= '0;
      ann_left  <= '0;
      level     <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
    end else begin
      if (buf_avail) ann_left <= chunk;
      else if (bus_fire) ann_left <= ann_left - 1'b1;
      if (bus_fire) bus_left <= bus_left - 1'b1;
      if (card_fire) card_left <= card_left - CNT_W'(step_n);
      level  <= level + push_n - pop_n;
      rd_ptr <= rd_ptr + pop_n[PTR_W-1:0];
      wr_ptr <= wr_ptr + push_n[PTR_W-1:0];
    end
  end
endmodule

// File: rtl/fifo_xfer_seq_chk.sv
module fifo_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [31:0] ctl_wdata,
  input logic [31:0] ctl_rdata,
  input logic        pio_err,
  input logic        card_req,
  input logic        buf_avail,
  input logic        done_evt
);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[31] |-> !card_req && !buf_avail && !done_evt);

  p_avail_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_avail && !ctl_we |=> !buf_avail);

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !ctl_we |=> !ctl_rdata[31]);

  p_events_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_avail && done_evt));

  p_zero_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[31] && ctl_wdata[17:0] == 18'd0 |=> done_evt && !card_req);

  p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pio_err && !ctl_we |=> !ctl_rdata[31] && !done_evt);
endmodule

bind fifo_xfer_seq fifo_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .pio_err(pio_err), .card_req(card_req),
  .buf_avail(buf_avail), .done_evt(done_evt)
);

// File: tb/fifo_xfer_seq_test.sv
`timescale 1ns/1ps
module fifo_xfer_seq_test;
  localparam int FIFO = 512;
  localparam logic [30:0] MASK = 31'h5F03_FFFF;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, pio_err = 0, bus_wr_en = 0, bus_rd_en = 0, card_ack = 0;
  logic [31:0] ctl_wdata = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] card_rdata = '0;
  logic [31:0] ctl_rdata;
  logic [7:0]  bus_rdata;
  logic [15:0] card_wdata;
  logic card_req, buf_avail, done_evt;

  always #5 clk = ~clk;

  fifo_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .pio_err(pio_err), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .card_req(card_req), .card_ack(card_ack), .card_wdata(card_wdata),
    .card_rdata(card_rdata), .buf_avail(buf_avail), .done_evt(done_evt)
  );

  int n_chk = 0, n_fail = 0;
  int n_av, n_dn, n_hs, n_req;
  bit m_active = 0;
  logic [30:0] m_cfg = '0;
  int m_card = 0, m_bus = 0, m_ann = 0;
  logic [7:0] q[$];

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clr_stats();
    n_av = 0; n_dn = 0; n_hs = 0; n_req = 0;
  endtask

  task automatic step(input bit we, input logic [31:0] wd, input bit err);
    int lvl, st, chunk, free_n;
    bit e_req, e_av, e_dn, e_ok, wdir, wide, ack, wr, rd, bus_f, card_f;
    logic [7:0] wb;
    logic [15:0] cr;
    @(negedge clk);
    wdir = m_cfg[30]; wide = m_cfg[25];
    lvl = q.size(); free_n = FIFO - lvl;
    st = (wide && m_card >= 2) ? 2 : 1;
    chunk = (m_bus < FIFO) ? m_bus : FIFO;
    e_req = m_active && m_card > 0 && (wdir ? lvl >= st : free_n >= st);
    e_av  = m_active && m_ann == 0 && m_bus > 0 && (wdir ? free_n >= chunk : lvl >= chunk);
    e_dn  = m_active && m_card == 0 && m_bus == 0;
    e_ok  = m_active && m_ann > 0 && (wdir ? lvl < FIFO : lvl > 0);
    cmp("R4 R5 buf_avail", 32'(buf_avail), 32'(e_av));
    cmp("R8 done_evt", 32'(done_evt), 32'(e_dn));
    cmp("R7 card_req", 32'(card_req), 32'(e_req));
    cmp("R2 R8 ctl_rdata", ctl_rdata, {m_active, m_cfg});
    if (e_req && wdir)
      cmp("R7 R11 card_wdata", 32'(card_wdata), (st == 2) ? 32'({q[1], q[0]}) : 32'({8'h00, q[0]}));
    if (e_ok && !wdir)
      cmp("R6 R11 bus_rdata", 32'(bus_rdata), 32'(q[0]));
    n_av += int'(buf_avail); n_dn += int'(done_evt); n_req += int'(card_req);

    ack = ($urandom % 4) != 0;
    wr = ($urandom % 3) != 0;
    rd = ($urandom % 3) != 0;
    wb = 8'($urandom);
    cr = 16'($urandom);
    ctl_we = we; ctl_wdata = wd; pio_err = err;
    bus_wr_en = wr; bus_rd_en = rd; bus_wdata = wb; card_ack = ack; card_rdata = cr;
    if (card_req && ack) n_hs++;

    if (we) begin
      m_cfg = wd[30:0] & MASK; m_active = wd[31];
      m_card = int'(wd[17:0]); m_bus = m_card; m_ann = 0; q.delete();
    end else if (err || e_dn) begin
      m_active = 0; m_card = 0; m_bus = 0; m_ann = 0; q.delete();
    end else begin
      if (e_av) m_ann = chunk;
      bus_f = e_ok && (wdir ? wr : rd);
      card_f = e_req && ack;
      if (wdir) begin
        if (card_f) repeat (st) void'(q.pop_front());
        if (bus_f) q.push_back(wb);
      end else begin
        if (bus_f) void'(q.pop_front());
        if (card_f) begin
          q.push_back(cr[7:0]);
          if (st == 2) q.push_back(cr[15:8]);
        end
      end
      if (bus_f) begin m_bus--; m_ann--; end
      if (card_f) m_card -= st;
    end
  endtask

  task automatic run_xfer(input logic [31:0] word, input int exp_av, input int exp_hs);
    clr_stats();
    step(1, word, 0);
    for (int i = 0; i < 20000 && (m_active || i == 0); i++) step(0, '0, 0);
    step(0, '0, 0);
    cmp("R4 R5 chunk pulses", 32'(n_av), 32'(exp_av));
    cmp("R8 one done pulse", 32'(n_dn), 32'd1);
    cmp("R7 handshake count", 32'(n_hs), 32'(exp_hs));
    cmp("R8 start cleared", 32'(ctl_rdata[31]), 32'd0);
  endtask

  initial begin
    #(190000 * 10);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #23;
    @(negedge clk);
    cmp("R1 reset readback", ctl_rdata, 32'h0);
    cmp("R1 reset events", 32'({buf_avail, done_evt}), 32'h0);
    cmp("R1 reset card_req", 32'(card_req), 32'h0);
    rst_n = 1;

    step(1, 32'h7FFF_FFFF, 0);
    step(0, '0, 0);
    cmp("R2 field readback", ctl_rdata, 32'h5F03_FFFF);
    step(1, 32'h0, 0);

    run_xfer(32'hC000_0000 | 32'd1300, 3, 1300);
    run_xfer(32'h8200_0000 | 32'd1025, 3, 513);
    run_xfer(32'hC200_0000 | 32'd3, 1, 2);
    run_xfer(32'h8000_0000 | 32'd600, 2, 600);

    clr_stats();
    step(1, 32'hC200_0000, 0);
    step(0, '0, 0);
    cmp("R9 zero count done", 32'(n_dn), 32'd1);
    cmp("R9 zero count quiet", 32'(n_req + n_av), 32'd0);
    step(0, '0, 0);

    step(1, 32'hC000_0000 | 32'd2000, 0);
    for (int i = 0; i < 150; i++) step(0, '0, 0);
    step(1, 32'h4000_0000 | 32'd2000, 0);
    clr_stats();
    for (int i = 0; i < 30; i++) step(0, '0, 0);
    cmp("R3 quiet after stop", 32'(n_av + n_dn + n_req), 32'd0);
    run_xfer(32'hC200_0000 | 32'd700, 2, 350);

    step(1, 32'h8200_0000 | 32'd4000, 0);
    for (int i = 0; i < 300; i++) step(0, '0, 0);
    step(0, '0, 1);
    clr_stats();
    for (int i = 0; i < 30; i++) step(0, '0, 0);
    cmp("R10 no done after error", 32'(n_dn), 32'd0);
    cmp("R10 start cleared", 32'(ctl_rdata[31]), 32'd0);
    cmp("R10 R3 quiet after error", 32'(n_av + n_req), 32'd0);
    run_xfer(32'h8000_0000 | 32'd513, 2, 513);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule